// File: doc/BRIEF.md
# Twisted Ring Step Sequencer

This block is a parameterized shift-register counter whose last stage is inverted and fed back into the first. With `STAGES` flip-flops it walks a closed cycle of twice that many patterns: the register first fills with ones from stage 0 upward, then empties again the same way. Consecutive patterns always differ in a single bit. Each stage bit is therefore a square wave at the clock divided by `2*STAGES`, and every step can be identified from just two register bits.

A decoder turns the current pattern into a one-hot step vector using one two-input AND per step. A guard watches for patterns that lie outside the legal cycle, for instance after a power-up upset. It raises a flag, silences the step vector and, on the next enabled edge, pulls the register back to all zeros. The parameter `POWERUP_PAT` sets the register's initial content before any reset, which is how such an upset is modelled.

Top module: `twist_ring_seq`

## Requirements
- R1: On a clock edge with `countEn` high, `rst` low and a legal pattern, stage k takes the old value of stage k-1 and stage 0 takes the inverse of the old stage `STAGES-1`.
- R2: `rst` is synchronous and outranks every other input: the edge on which it is high leaves all stages at 0, whatever `countEn` is.
- R3: With `STAGES`=4, starting from all zeros, the pattern Q0Q1Q2Q3 runs 1000, 1100, 1110, 1111, 0111, 0011, 0001, 0000 and then repeats, so the period is 8 enabled edges.
- R4: Every enabled step between legal patterns changes exactly one stage bit.
- R5: `stepHot` has `2*STAGES` bits. Bit i is set for the pattern reached i enabled edges after all zeros. Bit 0 decodes all zeros (not Q0 and not Qlast). Bit `STAGES` decodes all ones (Q0 and Qlast). For 1 <= k < `STAGES`, bit k is Q(k-1) and not Qk, and bit `STAGES`+k is not Q(k-1) and Qk.
- R6: While counting, each stage is high for `STAGES` clocks and low for `STAGES` clocks, and stage k repeats stage k-1 one clock later.
- R7: `badPattern` is high, combinationally, exactly when the stage bits, read from stage 0 to stage `STAGES-1` with no wrap, contain more than one change between 0 and 1.
- R8: On an edge with `countEn` high and `badPattern` high, the register loads all zeros instead of shifting.
- R9: `stepHot` is all zeros while `badPattern` is high.
- R10: With `countEn` low and `rst` low, the register holds its value, so `stepHot` and `badPattern` do not change.
- R11: With `STAGES`=2, Q0Q1 runs 10, 11, 01, 00, which gives two square waves a quarter period apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to all zeros, active high |
| countEn | input | 1 | Advance (or recover) on this edge |
| stageQ | output | STAGES | Raw stage bits; bit k is stage k |
| stepHot | output | 2*STAGES | One-hot step decode |
| badPattern | output | 1 | Register holds a pattern outside the legal cycle |

## Verification
Two functions can fall on the same edge: recovery from an illegal pattern and the ordinary shift. When both are due, recovery must win. The bench starts an instance whose power-up content is the illegal Q pattern 1010. It first holds that instance for a few edges with the enable low, checking that the flag and the silent step vector persist. It then gives one enabled edge and requires all zeros, not the shifted pattern 1101. A second such collision, reset together with an enable, is judged on the normal instance by requiring zeros rather than the next step.

// File: rtl/twist_ring_pkg.sv
package twist_ring_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic clearAll;  // load all zeros on this edge
    logic advance;   // shift with inverted feedback on this edge
  } ringCtl_t;
endpackage

// File: rtl/twist_ring_ctrl.sv
module twist_ring_ctrl
  import twist_ring_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              countEn,
  input  logic [STAGES-1:0] stateQ,
  output logic              badPattern,
  output ringCtl_t          ctl
);
  localparam int NBOUND = STAGES - 1;

  logic [NBOUND-1:0] boundary;

  // one flag per adjacent pair whose bits differ, no wrap-around
  always_comb begin
    for (int k = 0; k < NBOUND; k++) begin
      boundary[k] = stateQ[k] ^ stateQ[k+1];
    end
  end

  assign badPattern = ($countones(boundary) > 1);

  always_comb begin
    ctl.clearAll = rst | (countEn & badPattern);
    ctl.advance  = ~rst & countEn & ~badPattern;
  end

  // R8: an enabled edge on an illegal pattern lands on all zeros
  assert_recover_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (countEn && badPattern) |=> (stateQ == '0));

  // R2: the clear strobe and the shift strobe never coincide
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(ctl.clearAll && ctl.advance));
endmodule

// File: rtl/twist_ring_dp.sv
module twist_ring_dp
  import twist_ring_pkg::*;
#(
  parameter int              STAGES      = 4,
  parameter logic [STAGES-1:0] POWERUP_PAT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ringCtl_t          ctl,
  output logic [STAGES-1:0] stateQ
);
  logic [STAGES-1:0] stateR = POWERUP_PAT;
  logic [STAGES-1:0] shifted;

  // stage 0 takes the inverted last stage, the rest move up one place
  always_comb begin
    shifted[0] = ~stateR[STAGES-1];
    for (int k = 1; k < STAGES; k++) begin
      shifted[k] = stateR[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.clearAll) begin
      stateR <= '0;
    end else if (ctl.advance) begin
      stateR <= shifted;
    end
  end

  assign stateQ = stateR;

  // R4: a legal step flips exactly one stage
  assert_one_flip_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.advance |=> ($countones(stateR ^ $past(stateR)) == 1));

  // R10: no strobe, no change
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctl.advance && !ctl.clearAll) |=> $stable(stateR));
endmodule

// File: rtl/twist_ring_dec.sv
module twist_ring_dec #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0]   stateQ,
  input  logic                badPattern,
  output logic [2*STAGES-1:0] stepHot
);
  localparam int STEPS = 2 * STAGES;

  logic [STEPS-1:0] raw;

  // both ends low / both ends high
  assign raw[0]      = ~stateQ[0] & ~stateQ[STAGES-1];
  assign raw[STAGES] =  stateQ[0] &  stateQ[STAGES-1];

  // fill front at k, drain front at k
  for (genvar k = 1; k < STAGES; k++) begin : g_front
    assign raw[k]        =  stateQ[k-1] & ~stateQ[k];
    assign raw[STAGES+k] = ~stateQ[k-1] &  stateQ[k];
  end

  assign stepHot = badPattern ? '0 : raw;
endmodule

// File: rtl/twist_ring_seq.sv
module twist_ring_seq
  import twist_ring_pkg::*;
#(
  parameter int                STAGES      = 4,
  parameter logic [STAGES-1:0] POWERUP_PAT = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                countEn,
  output logic [STAGES-1:0]   stageQ,
  output logic [2*STAGES-1:0] stepHot,
  output logic                badPattern
);
  ringCtl_t ctl;

  twist_ring_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .countEn(countEn),
    .stateQ(stageQ), .badPattern(badPattern), .ctl(ctl)
  );

  twist_ring_dp #(.STAGES(STAGES), .POWERUP_PAT(POWERUP_PAT)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .stateQ(stageQ)
  );

  twist_ring_dec #(.STAGES(STAGES)) u_dec (
    .stateQ(stageQ), .badPattern(badPattern), .stepHot(stepHot)
  );

  // R2: first cycle after reset sees all zeros
  assert_reset_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stageQ == '0));

  // R5: a legal pattern gives exactly one step bit
  assert_one_step_R5: assert property (@(posedge clk) disable iff (rst)
    !badPattern |-> ($countones(stepHot) == 1));

  // R9: an illegal pattern gives no step bit
  assert_quiet_bad_R9: assert property (@(posedge clk) disable iff (rst)
    badPattern |-> (stepHot == '0));
endmodule

// File: tb/test_twist_ring_seq.sv
module test_twist_ring_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  // instance A: four stages, cleared power-up
  logic rstA = 1'b1, enA = 1'b0;
  logic [3:0] qA;  logic [7:0] hotA;  logic badA;
  twist_ring_seq #(.STAGES(4)) i_twist_ring_seq (
    .clk(clk), .rst(rstA), .countEn(enA),
    .stageQ(qA), .stepHot(hotA), .badPattern(badA));

  // instance B: four stages, powers up on Q0..Q3 = 1010
  logic rstB = 1'b0, enB = 1'b0;
  logic [3:0] qB;  logic [7:0] hotB;  logic badB;
  twist_ring_seq #(.STAGES(4), .POWERUP_PAT(4'b0101)) i_twist_ring_seq_bad (
    .clk(clk), .rst(rstB), .countEn(enB),
    .stageQ(qB), .stepHot(hotB), .badPattern(badB));

  // instance C: two stages
  logic rstC = 1'b1, enC = 1'b0;
  logic [1:0] qC;  logic [3:0] hotC;  logic badC;
  twist_ring_seq #(.STAGES(2)) i_twist_ring_seq_quad (
    .clk(clk), .rst(rstC), .countEn(enC),
    .stageQ(qC), .stepHot(hotC), .badPattern(badC));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_parasitic();
    // R7 R9: illegal power-up pattern is flagged and silent
    #1;
    chk(badB == 1'b1, "R7", 32'(badB), 1);
    chk(hotB == 8'h00, "R9", 32'(hotB), 0);
    // R10: with enable low the pattern stays put
    for (int i = 0; i < 2; i++) begin
      step();
      chk(qB == 4'b0101, "R10", 32'(qB), 32'h5);
      chk(badB == 1'b1, "R10", 32'(badB), 1);
    end
    // R8: enabled edge recovers to zeros, not the shifted 1101 (4'b1011)
    enB = 1'b1;
    step();
    chk(qB == 4'b0000, "R8", 32'(qB), 0);
    chk(badB == 1'b0, "R7", 32'(badB), 0);
    chk(hotB == 8'h01, "R5", 32'(hotB), 1);
    step();
    chk(qB == 4'b0001, "R1", 32'(qB), 1);
    enB = 1'b0;
  endtask

  task automatic t_reset();
    rstA = 1'b1; enA = 1'b0;
    step();
    chk(qA == 4'b0000, "R2", 32'(qA), 0);
    chk(hotA == 8'h01, "R5", 32'(hotA), 1);
    chk(badA == 1'b0, "R7", 32'(badA), 0);
    rstA = 1'b0;
  endtask

  task automatic t_sequence();
    // Q0..Q3 patterns as vectors, bit k = stage k
    logic [3:0] tbl [8] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111,
                            4'b1110, 4'b1100, 4'b1000, 4'b0000};
    logic [3:0] model = 4'b0000;
    logic [3:0] prev;
    int highs = 0;
    enA = 1'b1;
    for (int e = 0; e < 16; e++) begin
      prev = qA;
      model = {model[2:0], ~model[3]};
      step();
      chk(qA == model, "R1", 32'(qA), 32'(model));
      chk(qA == tbl[e % 8], "R3", 32'(qA), 32'(tbl[e % 8]));
      chk($countones(qA ^ prev) == 1, "R4", 32'(qA ^ prev), 0);
      chk(hotA == 8'(1 << ((e + 1) % 8)), "R5", 32'(hotA), 32'(1 << ((e + 1) % 8)));
      chk(badA == 1'b0, "R7", 32'(badA), 0);
      chk(qA[1] == prev[0] && qA[3] == prev[2], "R6", 32'(qA), 32'(prev));
      if (e < 8 && qA[3]) highs++;
    end
    chk(highs == 4, "R6", 32'(highs), 4);
  endtask

  task automatic t_hold();
    // now at 0000; step twice to 1100, then stall
    enA = 1'b1;
    step(); step();
    enA = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(qA == 4'b0011, "R10", 32'(qA), 32'h3);
      chk(hotA == 8'h04, "R10", 32'(hotA), 32'h4);
    end
    // R2: reset during hold
    rstA = 1'b1;
    step();
    chk(qA == 4'b0000, "R2", 32'(qA), 0);
    rstA = 1'b0;
  endtask

  task automatic t_reset_with_enable();
    enA = 1'b1;
    step(); step(); step();
    chk(qA == 4'b0111, "R1", 32'(qA), 32'h7);
    rstA = 1'b1;
    step();
    chk(qA == 4'b0000, "R2", 32'(qA), 0);
    rstA = 1'b0; enA = 1'b0;
  endtask

  task automatic t_quad();
    logic [1:0] tbl [4] = '{2'b01, 2'b11, 2'b10, 2'b00};
    logic [1:0] prev;
    rstC = 1'b1;
    step();
    chk(qC == 2'b00, "R2", 32'(qC), 0);
    rstC = 1'b0; enC = 1'b1;
    for (int e = 0; e < 8; e++) begin
      prev = qC;
      step();
      chk(qC == tbl[e % 4], "R11", 32'(qC), 32'(tbl[e % 4]));
      chk(qC[1] == prev[0], "R11", 32'(qC), 32'(prev));
      chk(hotC == 4'(1 << ((e + 1) % 4)), "R5", 32'(hotC), 32'(1 << ((e + 1) % 4)));
      chk(badC == 1'b0, "R7", 32'(badC), 0);
    end
    enC = 1'b0;
  endtask

  initial begin
    t_parasitic();
    t_reset();
    t_sequence();
    t_hold();
    t_reset_with_enable();
    t_quad();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule